// File: doc/BRIEF.md
# Channel-Tagged Mailbox

This block moves 32-bit message words between a host processor and a coprocessor through two small first-in first-out queues, one for each direction. Every word carries a 4-bit channel tag in bits 3:0 and a 28-bit payload in bits 31:4. The block passes every word through unchanged and does not look at the tag. Host software reads the tag to pick out the words meant for it. Each queue holds 8 words by default.

The host side is a small register port with four word addresses. The host polls the inbound status word until the empty flag clears, then reads the inbound data register. Each of those reads removes exactly one word. If the tag on that word is not the one software expects, software drops the word and polls again. Before sending, the host polls the outbound status word until the full flag clears, then writes the tagged word to the outbound data register.

The coprocessor side has two ports with valid/ready handshakes: one pushes words into the inbound queue and one takes words from the outbound queue. An optional interrupt output stays high while the inbound queue holds at least one word.

Top module: `chan_mailbox`

## Requirements
- R1: After reset both queues are empty, `irq_o` and `cop_pop_valid` are low, `cop_push_ready` is high and `cpu_rdata` is zero.
- R2: A host read of address 0 (inbound data) with the inbound queue not empty removes exactly one word, in arrival order. The word appears on `cpu_rdata` one cycle after the read.
- R3: A host read of address 0 while the inbound queue is empty returns the word most recently removed from that queue (zero if none), and leaves the queue unchanged.
- R4: A host read of address 1 (inbound status) returns the inbound full flag in bit 31 and the inbound empty flag in bit 30, with all other bits zero.
- R5: A host write to address 2 (outbound data) while the outbound queue is not full appends the word with all 32 bits, channel tag included, unchanged.
- R6: A host write to address 2 while the outbound queue is full is dropped and sets a sticky overflow flag. A host read of address 3 (outbound status) returns full in bit 31, empty in bit 30 and overflow in bit 29, and that read clears the overflow flag.
- R7: `cop_push_ready` is low exactly while the inbound queue holds its full depth. A push offered while ready is low is ignored.
- R8: `cop_pop_valid` is high while the outbound queue is not empty and `cop_pop_data` shows its oldest word. A cycle with both valid and ready removes that word. While ready is low the word stays on the port.
- R9: `irq_o` is high exactly while the inbound queue is not empty.
- R10: Host writes to addresses 0, 1 and 3 have no effect on either queue. A host read of address 2 returns zero.
- R11: A host access and coprocessor pushes and pops in the same cycle all take effect, each judged against the queue state before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Host access strobe, one access per cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Word address: 0 inbound data, 1 inbound status, 2 outbound data, 3 outbound status |
| cpu_wdata | input | 32 | Host write word |
| cpu_rdata | output | 32 | Registered host read word |
| cop_push_valid | input | 1 | Coprocessor offers an inbound word |
| cop_push_data | input | 32 | Inbound word |
| cop_push_ready | output | 1 | Inbound queue can accept a word |
| cop_pop_valid | output | 1 | Outbound word available |
| cop_pop_data | output | 32 | Oldest outbound word |
| cop_pop_ready | input | 1 | Coprocessor takes the outbound word |
| irq_o | output | 1 | Inbound queue not empty |

## Verification
The bench fills the inbound queue to its full depth and offers one more push. A design with an off-by-one count would accept a ninth word or drop the eighth. It reads the data register on an empty queue: a design that pops anyway would corrupt the read pointer, and one that returns the latest read value would leak a status word into the data path. The bench then writes to a full outbound queue and reads the outbound status twice, which catches an overflow flag that never sets, never clears, or clears itself. The bench also runs a long mixed stretch where host access, push and pop fall in the same cycles, which exposes designs that give one side priority or that judge an operation against the queue state after the cycle instead of before it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    REG_IN_DATA  = 2'd0,
    REG_IN_STAT  = 2'd1,
    REG_OUT_DATA = 2'd2,
    REG_OUT_STAT = 2'd3
  } mbox_reg_e;

  // status bit offsets measured down from the word's top bit
  localparam int unsigned FULL_OFS  = 1;
  localparam int unsigned EMPTY_OFS = 2;
  localparam int unsigned OVF_OFS   = 3;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nx;
  logic             do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign count_nx = count + CW'(do_wr) - CW'(do_rd);

  // storage without reset so the tools can map it to RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count_nx;
      full  <= (count_nx == CW'(DEPTH));
      empty <= (count_nx == '0);
    end
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] in_head,
  input  logic          in_full,
  input  logic          in_empty,
  input  logic          out_full,
  input  logic          out_empty,
  output logic          in_pop,
  output logic          out_push,
  output logic [DW-1:0] out_word,
  output logic [DW-1:0] rdata,
  output logic          ovf
);
  localparam int unsigned FULL_B  = DW - FULL_OFS;
  localparam int unsigned EMPTY_B = DW - EMPTY_OFS;
  localparam int unsigned OVF_B   = DW - OVF_OFS;

  mbox_reg_e     reg_sel;
  logic          rd_req, wr_req, ovf_set, ovf_clr;
  logic [DW-1:0] last_pop, rd_mux;

  assign reg_sel  = mbox_reg_e'(addr);
  assign rd_req   = sel && !wr;
  assign wr_req   = sel && wr;
  assign in_pop   = rd_req && (reg_sel == REG_IN_DATA) && !in_empty;
  assign out_push = wr_req && (reg_sel == REG_OUT_DATA) && !out_full;
  assign out_word = wdata;
  assign ovf_set  = wr_req && (reg_sel == REG_OUT_DATA) && out_full;
  assign ovf_clr  = rd_req && (reg_sel == REG_OUT_STAT);

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel)
      REG_IN_DATA:  rd_mux = in_empty ? last_pop : in_head;
      REG_IN_STAT: begin
        rd_mux[FULL_B]  = in_full;
        rd_mux[EMPTY_B] = in_empty;
      end
      REG_OUT_DATA: rd_mux = '0;
      REG_OUT_STAT: begin
        rd_mux[FULL_B]  = out_full;
        rd_mux[EMPTY_B] = out_empty;
        rd_mux[OVF_B]   = ovf;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      last_pop <= '0;
      ovf      <= 1'b0;
    end else begin
      if (rd_req) rdata <= rd_mux;
      if (in_pop) last_pop <= in_head;
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_mailbox.sv
module chan_mailbox #(
  parameter int unsigned DW        = 32,
  parameter int unsigned IN_DEPTH  = 8,
  parameter int unsigned OUT_DEPTH = 8,
  parameter bit          IRQ_EN    = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cop_push_valid,
  input  logic [DW-1:0] cop_push_data,
  output logic          cop_push_ready,
  output logic          cop_pop_valid,
  output logic [DW-1:0] cop_pop_data,
  input  logic          cop_pop_ready,
  output logic          irq_o
);
  logic          in_full, in_empty, in_pop;
  logic [DW-1:0] in_head;
  logic          out_full, out_empty, out_push;
  logic [DW-1:0] out_word;
  logic          ovf_flag;

  mbox_fifo #(.WIDTH(DW), .DEPTH(IN_DEPTH)) u_in_q (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cop_push_valid),
    .wr_data (cop_push_data),
    .rd_en   (in_pop),
    .rd_data (in_head),
    .full    (in_full),
    .empty   (in_empty)
  );

  mbox_fifo #(.WIDTH(DW), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (out_push),
    .wr_data (out_word),
    .rd_en   (cop_pop_ready),
    .rd_data (cop_pop_data),
    .full    (out_full),
    .empty   (out_empty)
  );

  mbox_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel       (cpu_sel),
    .wr        (cpu_wr),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .in_head   (in_head),
    .in_full   (in_full),
    .in_empty  (in_empty),
    .out_full  (out_full),
    .out_empty (out_empty),
    .in_pop    (in_pop),
    .out_push  (out_push),
    .out_word  (out_word),
    .rdata     (cpu_rdata),
    .ovf       (ovf_flag)
  );

  assign cop_push_ready = !in_full;
  assign cop_pop_valid  = !out_empty;

  generate
    if (IRQ_EN) begin : g_irq
      assign irq_o = !in_empty;
    end else begin : g_no_irq
      assign irq_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_sel,
  input logic          cpu_wr,
  input logic [1:0]    cpu_addr,
  input logic          cop_push_valid,
  input logic          cop_push_ready,
  input logic          cop_pop_valid,
  input logic [DW-1:0] cop_pop_data,
  input logic          cop_pop_ready,
  input logic          irq_o,
  input logic          out_full,
  input logic          ovf_flag
);
  logic in_read, out_wr, stat_rd;
  assign in_read = cpu_sel && !cpu_wr && (cpu_addr == 2'd0);
  assign out_wr  = cpu_sel && cpu_wr && (cpu_addr == 2'd2);
  assign stat_rd = cpu_sel && !cpu_wr && (cpu_addr == 2'd3);

  // R1: first cycle after reset shows the idle state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && !cop_pop_valid && cop_push_ready));

  // R9: an accepted push raises the interrupt
  p_irq_on_push_r9: assert property (@(posedge clk) disable iff (rst)
    (cop_push_valid && cop_push_ready) |=> irq_o);

  // R7: a full inbound queue stays full without a host data read
  p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!cop_push_ready && !in_read) |=> !cop_push_ready);

  // R8: a stalled outbound word holds
  p_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cop_pop_valid && !cop_pop_ready) |=> (cop_pop_valid && $stable(cop_pop_data)));

  // R6: a write into a full outbound queue sets the overflow flag
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (out_wr && out_full) |=> ovf_flag);

  // R6: the flag stays set until the outbound status is read
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !stat_rd) |=> ovf_flag);
endmodule

bind chan_mailbox mbox_checker #(.DW(DW)) u_mbox_checker (
  .clk            (clk),
  .rst            (rst),
  .cpu_sel        (cpu_sel),
  .cpu_wr         (cpu_wr),
  .cpu_addr       (cpu_addr),
  .cop_push_valid (cop_push_valid),
  .cop_push_ready (cop_push_ready),
  .cop_pop_valid  (cop_pop_valid),
  .cop_pop_data   (cop_pop_data),
  .cop_pop_ready  (cop_pop_ready),
  .irq_o          (irq_o),
  .out_full       (out_full),
  .ovf_flag       (ovf_flag)
);

// File: tb/chan_mailbox_tb.sv
`timescale 1ns/1ps
module chan_mailbox_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        cop_push_valid = 1'b0, cop_push_ready;
  logic [31:0] cop_push_data = '0;
  logic        cop_pop_valid, cop_pop_ready = 1'b0;
  logic [31:0] cop_pop_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] in_q[$];
  logic [31:0] out_q[$];
  logic [31:0] exp_rdata = '0;
  logic [31:0] last_pop  = '0;
  bit          exp_ovf   = 1'b0;

  always #2 clk = ~clk;

  chan_mailbox dut_i (
    .clk(clk), .rst(rst),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cop_push_valid(cop_push_valid), .cop_push_data(cop_push_data),
    .cop_push_ready(cop_push_ready),
    .cop_pop_valid(cop_pop_valid), .cop_pop_data(cop_pop_data),
    .cop_pop_ready(cop_pop_ready), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(cpu_rdata === exp_rdata, tag, "cpu_rdata", cpu_rdata, exp_rdata);
    chk(cop_push_ready === (in_q.size() < DEPTH), tag, "cop_push_ready",
        32'(cop_push_ready), 32'(in_q.size() < DEPTH));
    chk(cop_pop_valid === (out_q.size() > 0), tag, "cop_pop_valid",
        32'(cop_pop_valid), 32'(out_q.size() > 0));
    if (out_q.size() > 0)
      chk(cop_pop_data === out_q[0], tag, "cop_pop_data", cop_pop_data, out_q[0]);
    chk(irq_o === (in_q.size() > 0), tag, "irq_o", 32'(irq_o), 32'(in_q.size() > 0));
  endtask

  // one cycle: drive, clock, update the reference model, compare
  task automatic step(input bit sel, input bit wr, input logic [1:0] addr,
                      input logic [31:0] wd, input bit pv, input logic [31:0] pd,
                      input bit pr, input string tag);
    bit in_full, in_empty, out_full, out_empty;
    bit pop_in, push_in, push_out, pop_out, ovf_set, ovf_clr;
    @(negedge clk);
    cpu_sel = sel; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd;
    cop_push_valid = pv; cop_push_data = pd; cop_pop_ready = pr;
    @(posedge clk);
    in_full   = (in_q.size() == DEPTH);
    in_empty  = (in_q.size() == 0);
    out_full  = (out_q.size() == DEPTH);
    out_empty = (out_q.size() == 0);
    pop_in = 0; push_in = 0; push_out = 0; pop_out = 0; ovf_set = 0; ovf_clr = 0;
    if (sel && !wr) begin
      case (addr)
        2'd0: if (!in_empty) begin exp_rdata = in_q[0]; pop_in = 1; end
              else exp_rdata = last_pop;
        2'd1: exp_rdata = {in_full, in_empty, 30'b0};
        2'd2: exp_rdata = '0;
        default: begin
          exp_rdata = {out_full, out_empty, exp_ovf, 29'b0};
          ovf_clr = 1;
        end
      endcase
    end
    if (sel && wr && addr == 2'd2) begin
      if (out_full) ovf_set = 1; else push_out = 1;
    end
    if (pv && !in_full) push_in = 1;
    if (pr && !out_empty) pop_out = 1;
    if (pop_in) last_pop = in_q.pop_front();
    if (push_in) in_q.push_back(pd);
    if (pop_out) void'(out_q.pop_front());
    if (push_out) out_q.push_back(wd);
    if (ovf_set) exp_ovf = 1; else if (ovf_clr) exp_ovf = 0;
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 2'd0, '0, 0, '0, 0, tag);
  endtask

  task automatic host_rd(input logic [1:0] a, input string tag);
    step(1, 0, a, '0, 0, '0, 0, tag);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, '0, 0, tag);
  endtask

  task automatic cop_push(input logic [31:0] d, input string tag);
    step(0, 0, 2'd0, '0, 1, d, 0, tag);
  endtask

  task automatic cop_pop(input string tag);
    step(0, 0, 2'd0, '0, 0, '0, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    compare("R1");
    idle("R1");
    host_rd(2'd1, "R4");
    host_rd(2'd0, "R3");   // empty read before any pop returns zero

    // inbound path, several channel tags
    cop_push(32'hABCDE123, "R9");
    cop_push(32'h1234_5678, "R2");
    cop_push(32'hFFFF_FFFF, "R2");
    host_rd(2'd1, "R4");
    for (int i = 0; i < 3; i++) host_rd(2'd0, "R2");
    host_rd(2'd0, "R3");
    host_rd(2'd1, "R3");
    host_rd(2'd0, "R3");

    // fill to depth, overfill, simultaneous read and push
    for (int i = 0; i < DEPTH; i++) cop_push(32'h0000_1000 + 32'(i * 17), "R7");
    cop_push(32'hDEAD_BEE5, "R7");
    host_rd(2'd1, "R4");
    step(1, 0, 2'd0, '0, 1, 32'hCAFE_0007, 0, "R11");
    for (int i = 0; i < DEPTH + 1; i++) host_rd(2'd0, "R2");

    // outbound path
    for (int i = 0; i < DEPTH; i++) host_wr(2'd2, 32'h5A5A_0000 + 32'(i), "R5");
    host_wr(2'd2, 32'h0BAD_0009, "R6");
    idle("R6");
    host_rd(2'd3, "R6");
    host_rd(2'd3, "R6");
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) idle("R8");
      cop_pop("R8");
    end
    cop_pop("R8");
    host_rd(2'd3, "R6");

    // writes to non-data addresses and read of the write-only register
    host_wr(2'd0, 32'h1111_1111, "R10");
    host_wr(2'd1, 32'h2222_2222, "R10");
    host_wr(2'd3, 32'h3333_3333, "R10");
    host_rd(2'd1, "R10");
    host_rd(2'd3, "R10");
    host_rd(2'd2, "R10");

    // mixed traffic on both sides at once
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1], lfsr[3:2], {lfsr[31:8], 4'h0, lfsr[7:4]},
           lfsr[5], {lfsr[15:0], lfsr[31:16]}, lfsr[9] | lfsr[10], "R11");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule